// File: doc/BRIEF.md
# Floppy Recording-Mode and Lock Register Unit

This block holds the command parameters that decide how a floppy disk controller records on each drive. A two-bit global recording-mode field picks conventional recording, perpendicular recording at 500 Kbps or perpendicular recording at 1 Mbps. A set of per-drive perpendicular bits, one for each of four drives, can place single drives in perpendicular mode while the global field is zero. A per-command update enable decides whether a mode command may rewrite the per-drive bits. For the currently selected drive and data-rate code, the unit produces three combinational outputs: the GAP2 length used when formatting, the number of GAP2 bytes a write lays down, and the write-precompensation code to apply.

The unit also holds a lock bit and three FIFO configuration parameters: a FIFO-disable flag, a FIFO threshold and a precompensation start track. The lock bit decides whether a software reset may return those parameters to their defaults. The unit takes two reset inputs. A hardware reset clears everything. A software reset clears only the global mode field and, when the lock bit is clear, the configuration parameters. Command parsing feeds the unit one-cycle strobes. All registers update on the rising clock edge, and both resets are sampled there.

Top module: `fdc_recmode_regs`

## Requirements
- R1: When `hw_rst` is 1 at a clock edge, the next state is: `rec_mode_q`=00, `drv_perp_q`=0000, `lock_q`=0, `fifo_off_q`=1, `fifo_thr_q`=0, `pc_trk_q`=0.
- R2: When no reset is active and `mode_wr` is 1, `rec_mode_q` loads `mode_in` (bit 1 selects the 1 Mbps mode, bit 0 selects the 500 Kbps mode). `drv_perp_q` loads `drv_perp_in` only when `drv_upd_en` is 1 and is kept otherwise.
- R3: A software reset (`sw_rst`=1 with `hw_rst`=0) clears `rec_mode_q` to 00 and leaves `drv_perp_q` and `lock_q` unchanged.
- R4: On a software reset, if `lock_q` is 1 then `fifo_off_q`, `fifo_thr_q` and `pc_trk_q` keep their values. If `lock_q` is 0 they return to 1, 0 and 0.
- R5: When no reset is active, `lock_wr` loads `lock_in` into `lock_q`, and `cfg_wr` loads `cfg_fifo_off`, `cfg_fifo_thr` and `cfg_pc_trk`. Both strobes may act in the same cycle.
- R6: The global mode `rec_mode_q` overrides the per-drive bits whenever it is not 00. Mode 01 gives `fmt_gap2`=22, `wr_gap2`=19 and `sel_perp`=1. Mode 11 gives 41/38 and `sel_perp`=1. Mode 10 is treated as conventional and gives 22/0 with `sel_perp`=0. In all three cases the per-drive bits have no effect.
- R7: With `rec_mode_q`=00, the selected drive (`drv_sel`) is perpendicular when its `drv_perp_q` bit is 1. It then gives 41/38 if `rate_sel`=11 (the 1 Mbps code) and 22/19 for any other rate code. A drive whose bit is 0 gives 22/0.
- R8: `precomp_out` is 000 (0 ns) when the selected drive is perpendicular (`sel_perp`=1) and equals `precomp_in` otherwise.
- R9: When `hw_rst` and `sw_rst` are both 1, the hardware reset applies in full, including clearing a set lock bit. Either reset overrides any `mode_wr`, `lock_wr` or `cfg_wr` strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| hw_rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset from the control registers, synchronous, active high |
| mode_wr | input | 1 | One-cycle strobe of a recording-mode command |
| mode_in | input | 2 | Global recording-mode field of the command |
| drv_upd_en | input | 1 | Command allows the per-drive bits to be rewritten |
| drv_perp_in | input | 4 | Per-drive perpendicular bits of the command |
| lock_wr | input | 1 | One-cycle strobe of a lock command |
| lock_in | input | 1 | Lock value of the command |
| cfg_wr | input | 1 | One-cycle strobe of a configuration command |
| cfg_fifo_off | input | 1 | FIFO-disable value of the command |
| cfg_fifo_thr | input | 4 | FIFO threshold value of the command |
| cfg_pc_trk | input | 8 | Precompensation start track of the command |
| drv_sel | input | 2 | Currently selected drive |
| rate_sel | input | 2 | Data-rate code, 11 = 1 Mbps |
| precomp_in | input | 3 | Programmed write-precompensation code |
| rec_mode_q | output | 2 | Stored global recording mode |
| drv_perp_q | output | 4 | Stored per-drive perpendicular bits |
| lock_q | output | 1 | Stored lock bit |
| fifo_off_q | output | 1 | Stored FIFO-disable flag |
| fifo_thr_q | output | 4 | Stored FIFO threshold |
| pc_trk_q | output | 8 | Stored precompensation start track |
| sel_perp | output | 1 | Selected drive records perpendicularly |
| fmt_gap2 | output | 6 | GAP2 length for a format operation |
| wr_gap2 | output | 6 | GAP2 bytes laid down by a write operation |
| precomp_out | output | 3 | Write-precompensation code to apply |

## Verification
On every cycle, the assertions check the register rules. These cover what each reset kind clears or keeps, the update-enable guard on the per-drive bits, and lock protection of the configuration parameters. They also check that the stored global mode and the per-drive bits always produce the matching GAP2 pair and precompensation. Other behaviours need scenarios that only the bench builds. These are a hardware and a software reset arriving together while the lock is set, a reset overriding command strobes in the same cycle, and per-drive perpendicular mode being followed as the selected drive and the data-rate code change.

// File: rtl/fdc_rm_pkg.sv
package fdc_rm_pkg;

    // Kind of reset seen at a clock edge; hardware outranks software.
    typedef enum logic [1:0] {
        RST_NONE = 2'd0,
        RST_SOFT = 2'd1,
        RST_HARD = 2'd2
    } rst_kind_e;

    // Global recording mode, bit 1 = 1 Mbps perpendicular, bit 0 = 500 Kbps.
    typedef enum logic [1:0] {
        MODE_CONV = 2'b00,
        MODE_P500 = 2'b01,
        MODE_RSVD = 2'b10,
        MODE_P1M  = 2'b11
    } recmode_e;

    localparam logic [1:0]  RATE_1MBPS    = 2'b11;
    localparam int unsigned FMT_GAP2_STD  = 22;
    localparam int unsigned FMT_GAP2_FAST = 41;
    localparam int unsigned WR_GAP2_STD   = 19;
    localparam int unsigned WR_GAP2_FAST  = 38;

    function automatic rst_kind_e classify_reset(input logic hw, input logic sw);
        if (hw) begin
            return RST_HARD;
        end
        if (sw) begin
            return RST_SOFT;
        end
        return RST_NONE;
    endfunction

endpackage

// File: rtl/fdc_perp_regs.sv
module fdc_perp_regs
    import fdc_rm_pkg::*;
#(
    parameter int unsigned NUM_DRV = 4
) (
    input  logic               clk,
    input  rst_kind_e          rst_kind,
    input  logic               wr_en,
    input  logic [1:0]         mode_in,
    input  logic               upd_en,
    input  logic [NUM_DRV-1:0] drv_in,
    output logic [1:0]         mode_q,
    output logic [NUM_DRV-1:0] drv_q
);

    // Global mode: cleared by either reset kind.
    always_ff @(posedge clk) begin
        unique case (rst_kind)
            RST_HARD: mode_q <= '0;
            RST_SOFT: mode_q <= '0;
            RST_NONE: begin
                if (wr_en) begin
                    mode_q <= mode_in;
                end
            end
            default:  mode_q <= mode_q;
        endcase
    end

    // Per-drive bits: only a hardware reset clears them.
    for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst_kind == RST_HARD) begin
                bit_q <= 1'b0;
            end else if (rst_kind == RST_NONE && wr_en && upd_en) begin
                bit_q <= drv_in[g];
            end
        end
        assign drv_q[g] = bit_q;
    end

    p_hw_clear_r1: assert property (@(posedge clk) disable iff (rst_kind == RST_HARD)
        $past(rst_kind == RST_HARD) |-> (mode_q == 2'b00 && drv_q == '0));

    p_mode_load_r2: assert property (@(posedge clk) disable iff (rst_kind == RST_HARD)
        (rst_kind == RST_NONE && wr_en) |=> (mode_q == $past(mode_in)));

    p_ow_guard_r2: assert property (@(posedge clk) disable iff (rst_kind == RST_HARD)
        (rst_kind == RST_NONE && wr_en && !upd_en) |=> $stable(drv_q));

    p_sw_clear_r3: assert property (@(posedge clk) disable iff (rst_kind == RST_HARD)
        (rst_kind == RST_SOFT) |=> (mode_q == 2'b00 && $stable(drv_q)));

endmodule

// File: rtl/fdc_lock_cfg.sv
module fdc_lock_cfg
    import fdc_rm_pkg::*;
#(
    parameter int unsigned THR_W = 4,
    parameter int unsigned TRK_W = 8
) (
    input  logic             clk,
    input  rst_kind_e        rst_kind,
    input  logic             lock_wr,
    input  logic             lock_in,
    input  logic             cfg_wr,
    input  logic             cfg_fifo_off,
    input  logic [THR_W-1:0] cfg_thr,
    input  logic [TRK_W-1:0] cfg_trk,
    output logic             lock_q,
    output logic             fifo_off_q,
    output logic [THR_W-1:0] thr_q,
    output logic [TRK_W-1:0] trk_q
);

    localparam logic             DEF_FIFO_OFF = 1'b1;
    localparam logic [THR_W-1:0] DEF_THR      = '0;
    localparam logic [TRK_W-1:0] DEF_TRK      = '0;

    always_ff @(posedge clk) begin
        unique case (rst_kind)
            RST_HARD: begin
                lock_q     <= 1'b0;
                fifo_off_q <= DEF_FIFO_OFF;
                thr_q      <= DEF_THR;
                trk_q      <= DEF_TRK;
            end
            RST_SOFT: begin
                if (!lock_q) begin
                    fifo_off_q <= DEF_FIFO_OFF;
                    thr_q      <= DEF_THR;
                    trk_q      <= DEF_TRK;
                end
            end
            default: begin
                if (lock_wr) begin
                    lock_q <= lock_in;
                end
                if (cfg_wr) begin
                    fifo_off_q <= cfg_fifo_off;
                    thr_q      <= cfg_thr;
                    trk_q      <= cfg_trk;
                end
            end
        endcase
    end

    p_hw_default_r1: assert property (@(posedge clk) disable iff (rst_kind == RST_HARD)
        $past(rst_kind == RST_HARD) |->
            (!lock_q && fifo_off_q && thr_q == '0 && trk_q == '0));

    p_locked_keep_r4: assert property (@(posedge clk) disable iff (rst_kind == RST_HARD)
        (rst_kind == RST_SOFT && lock_q) |=>
            ($stable({fifo_off_q, thr_q, trk_q}) && lock_q));

    p_unlocked_default_r4: assert property (@(posedge clk) disable iff (rst_kind == RST_HARD)
        (rst_kind == RST_SOFT && !lock_q) |=>
            (fifo_off_q && thr_q == '0 && trk_q == '0 && !lock_q));

    p_lock_load_r5: assert property (@(posedge clk) disable iff (rst_kind == RST_HARD)
        (rst_kind == RST_NONE && lock_wr) |=> (lock_q == $past(lock_in)));

    p_cfg_load_r5: assert property (@(posedge clk) disable iff (rst_kind == RST_HARD)
        (rst_kind == RST_NONE && cfg_wr) |=>
            ({fifo_off_q, thr_q, trk_q} == $past({cfg_fifo_off, cfg_thr, cfg_trk})));

endmodule

// File: rtl/fdc_gap_select.sv
module fdc_gap_select
    import fdc_rm_pkg::*;
#(
    parameter int unsigned NUM_DRV = 4,
    parameter int unsigned SEL_W   = 2,
    parameter int unsigned PC_W    = 3,
    parameter int unsigned GAP_W   = 6
) (
    input  logic [1:0]         mode_q,
    input  logic [NUM_DRV-1:0] drv_q,
    input  logic [SEL_W-1:0]   drv_sel,
    input  logic [1:0]         rate_sel,
    input  logic [PC_W-1:0]    precomp_in,
    output logic               sel_perp,
    output logic [GAP_W-1:0]   fmt_gap2,
    output logic [GAP_W-1:0]   wr_gap2,
    output logic [PC_W-1:0]    precomp_out
);

    recmode_e mode;
    logic     fast;

    assign mode = recmode_e'(mode_q);

    // Decide whether the selected drive records perpendicularly, and at which rate.
    always_comb begin
        sel_perp = 1'b0;
        fast     = 1'b0;
        unique case (mode)
            MODE_CONV: begin
                sel_perp = drv_q[drv_sel];
                fast     = (rate_sel == RATE_1MBPS);
            end
            MODE_P500: begin
                sel_perp = 1'b1;
                fast     = 1'b0;
            end
            MODE_RSVD: begin
                sel_perp = 1'b0;
                fast     = 1'b0;
            end
            MODE_P1M: begin
                sel_perp = 1'b1;
                fast     = 1'b1;
            end
            default: begin
                sel_perp = 1'b0;
                fast     = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (sel_perp && fast) begin
            fmt_gap2 = GAP_W'(FMT_GAP2_FAST);
            wr_gap2  = GAP_W'(WR_GAP2_FAST);
        end else if (sel_perp) begin
            fmt_gap2 = GAP_W'(FMT_GAP2_STD);
            wr_gap2  = GAP_W'(WR_GAP2_STD);
        end else begin
            fmt_gap2 = GAP_W'(FMT_GAP2_STD);
            wr_gap2  = '0;
        end
        precomp_out = sel_perp ? '0 : precomp_in;
    end

endmodule

// File: rtl/fdc_recmode_regs.sv
module fdc_recmode_regs
    import fdc_rm_pkg::*;
#(
    parameter int unsigned NUM_DRV = 4,
    parameter int unsigned THR_W   = 4,
    parameter int unsigned TRK_W   = 8,
    parameter int unsigned PC_W    = 3,
    parameter int unsigned GAP_W   = 6,
    localparam int unsigned SEL_W  = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
    input  logic               clk,
    input  logic               hw_rst,
    input  logic               sw_rst,
    input  logic               mode_wr,
    input  logic [1:0]         mode_in,
    input  logic               drv_upd_en,
    input  logic [NUM_DRV-1:0] drv_perp_in,
    input  logic               lock_wr,
    input  logic               lock_in,
    input  logic               cfg_wr,
    input  logic               cfg_fifo_off,
    input  logic [THR_W-1:0]   cfg_fifo_thr,
    input  logic [TRK_W-1:0]   cfg_pc_trk,
    input  logic [SEL_W-1:0]   drv_sel,
    input  logic [1:0]         rate_sel,
    input  logic [PC_W-1:0]    precomp_in,
    output logic [1:0]         rec_mode_q,
    output logic [NUM_DRV-1:0] drv_perp_q,
    output logic               lock_q,
    output logic               fifo_off_q,
    output logic [THR_W-1:0]   fifo_thr_q,
    output logic [TRK_W-1:0]   pc_trk_q,
    output logic               sel_perp,
    output logic [GAP_W-1:0]   fmt_gap2,
    output logic [GAP_W-1:0]   wr_gap2,
    output logic [PC_W-1:0]    precomp_out
);

    rst_kind_e rst_kind;

    // Hardware reset has priority over software reset (R9).
    assign rst_kind = classify_reset(hw_rst, sw_rst);

    fdc_perp_regs #(
        .NUM_DRV (NUM_DRV)
    ) u_perp (
        .clk      (clk),
        .rst_kind (rst_kind),
        .wr_en    (mode_wr),
        .mode_in  (mode_in),
        .upd_en   (drv_upd_en),
        .drv_in   (drv_perp_in),
        .mode_q   (rec_mode_q),
        .drv_q    (drv_perp_q)
    );

    fdc_lock_cfg #(
        .THR_W (THR_W),
        .TRK_W (TRK_W)
    ) u_lock (
        .clk          (clk),
        .rst_kind     (rst_kind),
        .lock_wr      (lock_wr),
        .lock_in      (lock_in),
        .cfg_wr       (cfg_wr),
        .cfg_fifo_off (cfg_fifo_off),
        .cfg_thr      (cfg_fifo_thr),
        .cfg_trk      (cfg_pc_trk),
        .lock_q       (lock_q),
        .fifo_off_q   (fifo_off_q),
        .thr_q        (fifo_thr_q),
        .trk_q        (pc_trk_q)
    );

    fdc_gap_select #(
        .NUM_DRV (NUM_DRV),
        .SEL_W   (SEL_W),
        .PC_W    (PC_W),
        .GAP_W   (GAP_W)
    ) u_gap (
        .mode_q      (rec_mode_q),
        .drv_q       (drv_perp_q),
        .drv_sel     (drv_sel),
        .rate_sel    (rate_sel),
        .precomp_in  (precomp_in),
        .sel_perp    (sel_perp),
        .fmt_gap2    (fmt_gap2),
        .wr_gap2     (wr_gap2),
        .precomp_out (precomp_out)
    );

    p_fast_perp_r6: assert property (@(posedge clk) disable iff (hw_rst)
        (rec_mode_q == 2'b11) |->
            (fmt_gap2 == GAP_W'(41) && wr_gap2 == GAP_W'(38) && sel_perp));

    p_slow_perp_r6: assert property (@(posedge clk) disable iff (hw_rst)
        (rec_mode_q == 2'b01) |->
            (fmt_gap2 == GAP_W'(22) && wr_gap2 == GAP_W'(19) && sel_perp));

    p_rsvd_conv_r6: assert property (@(posedge clk) disable iff (hw_rst)
        (rec_mode_q == 2'b10) |->
            (fmt_gap2 == GAP_W'(22) && wr_gap2 == '0 && precomp_out == precomp_in));

    p_drv_bit_r7: assert property (@(posedge clk) disable iff (hw_rst)
        (rec_mode_q == 2'b00 && drv_perp_q[drv_sel]) |->
            (wr_gap2 != '0 && precomp_out == '0));

    p_conv_precomp_r8: assert property (@(posedge clk) disable iff (hw_rst)
        (rec_mode_q == 2'b00 && !drv_perp_q[drv_sel]) |->
            (precomp_out == precomp_in && wr_gap2 == '0 && !sel_perp));

endmodule

// File: tb/sim_fdc_recmode_regs.sv
`timescale 1ns/1ps
module sim_fdc_recmode_regs;

    logic       clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       hw_rst, sw_rst, mode_wr, drv_upd_en, lock_wr, lock_in;
    logic       cfg_wr, cfg_fifo_off;
    logic [1:0] mode_in, drv_sel, rate_sel;
    logic [3:0] drv_perp_in, cfg_fifo_thr;
    logic [7:0] cfg_pc_trk;
    logic [2:0] precomp_in;

    logic [1:0] rec_mode_q;
    logic [3:0] drv_perp_q, fifo_thr_q;
    logic       lock_q, fifo_off_q, sel_perp;
    logic [7:0] pc_trk_q;
    logic [5:0] fmt_gap2, wr_gap2;
    logic [2:0] precomp_out;

    fdc_recmode_regs u0 (
        .clk(clk), .hw_rst(hw_rst), .sw_rst(sw_rst),
        .mode_wr(mode_wr), .mode_in(mode_in), .drv_upd_en(drv_upd_en),
        .drv_perp_in(drv_perp_in), .lock_wr(lock_wr), .lock_in(lock_in),
        .cfg_wr(cfg_wr), .cfg_fifo_off(cfg_fifo_off), .cfg_fifo_thr(cfg_fifo_thr),
        .cfg_pc_trk(cfg_pc_trk), .drv_sel(drv_sel), .rate_sel(rate_sel),
        .precomp_in(precomp_in), .rec_mode_q(rec_mode_q), .drv_perp_q(drv_perp_q),
        .lock_q(lock_q), .fifo_off_q(fifo_off_q), .fifo_thr_q(fifo_thr_q),
        .pc_trk_q(pc_trk_q), .sel_perp(sel_perp), .fmt_gap2(fmt_gap2),
        .wr_gap2(wr_gap2), .precomp_out(precomp_out)
    );

    typedef struct {
        string       tag;
        logic [35:0] vec;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    // Reference state, kept from the requirements.
    logic [1:0] m_mode;
    logic [3:0] m_drv, m_thr;
    logic       m_lock, m_fo;
    logic [7:0] m_trk;

    function automatic logic [35:0] expected_vec();
        logic       perp, fast;
        logic [5:0] f, w;
        logic [2:0] p;
        perp = (m_mode == 2'b01) || (m_mode == 2'b11) || (m_mode == 2'b00 && m_drv[drv_sel]);
        fast = (m_mode == 2'b11) || (m_mode == 2'b00 && rate_sel == 2'b11);
        f = (perp && fast) ? 6'd41 : 6'd22;
        w = perp ? (fast ? 6'd38 : 6'd19) : 6'd0;
        p = perp ? 3'd0 : precomp_in;
        return {m_mode, m_drv, m_lock, m_fo, m_thr, m_trk, perp, f, w, p};
    endfunction

    task automatic clear_strobes();
        hw_rst = 1'b0; sw_rst = 1'b0; mode_wr = 1'b0; lock_wr = 1'b0; cfg_wr = 1'b0;
    endtask

    // Driver: apply one clock, update the reference, push the expected item.
    task automatic cycle(input string tag);
        logic [1:0] n_mode;
        logic [3:0] n_drv, n_thr;
        logic       n_lock, n_fo;
        logic [7:0] n_trk;
        exp_t       e;
        n_mode = m_mode; n_drv = m_drv; n_lock = m_lock;
        n_fo = m_fo; n_thr = m_thr; n_trk = m_trk;
        if (hw_rst) begin
            n_mode = 2'b00; n_drv = 4'b0000; n_lock = 1'b0;
            n_fo = 1'b1; n_thr = 4'd0; n_trk = 8'd0;
        end else if (sw_rst) begin
            n_mode = 2'b00;
            if (!m_lock) begin
                n_fo = 1'b1; n_thr = 4'd0; n_trk = 8'd0;
            end
        end else begin
            if (mode_wr) begin
                n_mode = mode_in;
                if (drv_upd_en) n_drv = drv_perp_in;
            end
            if (lock_wr) n_lock = lock_in;
            if (cfg_wr) begin
                n_fo = cfg_fifo_off; n_thr = cfg_fifo_thr; n_trk = cfg_pc_trk;
            end
        end
        @(posedge clk);
        m_mode = n_mode; m_drv = n_drv; m_lock = n_lock;
        m_fo = n_fo; m_thr = n_thr; m_trk = n_trk;
        #1;
        e.tag = tag;
        e.vec = expected_vec();
        sb_q.push_back(e);
        @(negedge clk);
        clear_strobes();
    endtask

    // Monitor: compare outputs once per cycle, after the driver has pushed.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t        e;
                logic [35:0] act;
                e   = sb_q.pop_front();
                act = {rec_mode_q, drv_perp_q, lock_q, fifo_off_q, fifo_thr_q,
                       pc_trk_q, sel_perp, fmt_gap2, wr_gap2, precomp_out};
                n_chk++;
                if (act !== e.vec) begin
                    n_bad++;
                    $display("FAIL %s: actual=%h expected=%h", e.tag, act, e.vec);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (R1 sequence): actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_strobes();
        mode_in = 2'b00; drv_upd_en = 1'b0; drv_perp_in = 4'b0000; lock_in = 1'b0;
        cfg_fifo_off = 1'b0; cfg_fifo_thr = 4'd0; cfg_pc_trk = 8'd0;
        drv_sel = 2'd0; rate_sel = 2'b00; precomp_in = 3'b101;
        m_mode = 2'b00; m_drv = 4'b0000; m_lock = 1'b0;
        m_fo = 1'b0; m_thr = 4'd0; m_trk = 8'd0;

        // R1: hardware reset state
        hw_rst = 1'b1; cycle("R1 hw reset");
        cycle("R1 idle after reset");

        // R2: per-drive bits written with update enable
        mode_wr = 1'b1; mode_in = 2'b00; drv_upd_en = 1'b1; drv_perp_in = 4'b0101;
        cycle("R2 load drive bits");

        // R7/R8: drive 0 perpendicular, rate-dependent gaps
        cycle("R7 drv0 slow rate 22/19, R8 precomp 0");
        rate_sel = 2'b11; cycle("R7 drv0 1 Mbps 41/38");
        drv_sel = 2'd1;   cycle("R8 drv1 conventional keeps precomp");

        // R2/R6: update enable clear keeps drive bits; mode 01
        mode_wr = 1'b1; mode_in = 2'b01; drv_upd_en = 1'b0; drv_perp_in = 4'b1111;
        cycle("R2 guard, R6 mode 01 22/19");

        // R6: reserved mode ignores drive bits
        mode_wr = 1'b1; mode_in = 2'b10; drv_upd_en = 1'b1; drv_perp_in = 4'b0010;
        cycle("R6 mode 10 conventional");

        // R6: mode 11 overrides the clear drive bit of drive 0
        drv_sel = 2'd0; rate_sel = 2'b00;
        mode_wr = 1'b1; mode_in = 2'b11; drv_upd_en = 1'b0;
        cycle("R6 mode 11 41/38");

        // R5: configuration load
        cfg_wr = 1'b1; cfg_fifo_off = 1'b0; cfg_fifo_thr = 4'd7; cfg_pc_trk = 8'h20;
        cycle("R5 cfg load");

        // R3/R4: software reset while unlocked
        sw_rst = 1'b1; cycle("R3 R4 sw reset unlocked");
        drv_sel = 2'd1; rate_sel = 2'b01; cycle("R7 drv1 kept bit 22/19");

        // R5: lock and configure in the same cycle
        lock_wr = 1'b1; lock_in = 1'b1;
        cfg_wr = 1'b1; cfg_fifo_off = 1'b0; cfg_fifo_thr = 4'd9; cfg_pc_trk = 8'h33;
        cycle("R5 lock and cfg together");

        // R9/R4: software reset beats a mode write; locked cfg kept
        sw_rst = 1'b1; mode_wr = 1'b1; mode_in = 2'b11; drv_upd_en = 1'b1; drv_perp_in = 4'b0000;
        cycle("R9 R4 sw reset over write, locked");

        mode_wr = 1'b1; mode_in = 2'b01; drv_upd_en = 1'b0;
        cycle("R2 mode 01 before combined reset");

        // R9: both resets together with lock set
        hw_rst = 1'b1; sw_rst = 1'b1; cycle("R9 hw and sw together");

        // R9: hardware reset beats cfg and lock strobes
        hw_rst = 1'b1; cfg_wr = 1'b1; cfg_fifo_thr = 4'd3; lock_wr = 1'b1; lock_in = 1'b1;
        cycle("R9 hw reset over cfg write");
        drv_sel = 2'd3; precomp_in = 3'b011; cycle("R8 conventional after reset");

        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule